// File: doc/BRIEF.md
# IPv4 Forwarding Decision Engine with Control-Processor Punt

This block makes the per-packet forwarding decision for a router data path. Every packet arrives as a short header descriptor: a buffer tag that names where the payload sits, the destination IPv4 address and the port it came in on. The payload never enters the block. For each descriptor the engine produces exactly one result. The result is either an egress descriptor, which gives the buffer tag, the outgoing port and the next-hop MAC so that a rewritten header can be joined to the stored payload, or a punt descriptor for the control processor with a reason code.

The engine holds three tables that the control processor writes through a configuration port, which is kept apart from the packet path. The first is a longest-prefix-match route table that maps a prefix to an egress port and a next-hop address. The second is an adjacency table that maps a next-hop address to a MAC. The third is a small set of the router's own addresses. Adjacency entries age: a global tick advances every entry's age, and an entry that has not been rewritten within a programmable number of ticks stops matching.

The sequence is run by a five-state machine:
- IDLE accepts a descriptor.
- ROUTE checks the local addresses and the route table.
- ADJ resolves the next hop.
- EMIT_FWD or EMIT_PUNT holds the result until the downstream side takes it.

Transitions:
- IDLE→ROUTE: a descriptor is accepted.
- ROUTE→EMIT_PUNT: the destination is local or has no route.
- ROUTE→ADJ: a route matches.
- ADJ→EMIT_FWD: the adjacency hits.
- ADJ→EMIT_PUNT: the adjacency misses (glean).
- EMIT_FWD→IDLE and EMIT_PUNT→IDLE: the output handshake completes.

Top module: `l3_fwd_engine`

## Requirements
- R1: A destination equal to a programmed own address, or to 224.0.0.5 (0xE0000005), is punted with reason 0 and punt_ip equal to the destination, even when a route also matches it.
- R2: Among the valid route entries whose first `len` bits equal the destination's, the entry with the largest `len` is chosen; on equal length the lower index wins. A forwarded packet carries that entry's port and the MAC of the adjacency entry that holds its next-hop address.
- R3: A destination that matches no valid route and is not local is punted with reason 2 and punt_ip equal to the destination.
- R4: When a route matches but no usable adjacency entry holds its next-hop address, the packet is punted with reason 1 (glean) and punt_ip equal to that next-hop address.
- R5: The buffer tag of the accepted descriptor appears unchanged on whichever output carries its result. A punt also carries the ingress port.
- R6: A configuration write sets an adjacency entry to age 0 and makes it valid. Each tick adds one to the age of every valid entry. An entry stops matching once its age reaches age_limit. A write in the same cycle as a tick leaves the entry at age 0. When two usable entries hold the same address, the lower index supplies the MAC.
- R7: Each accepted descriptor yields exactly one output descriptor. An output whose ready is low keeps valid high and all of its fields stable. in_ready is low from acceptance until the output handshake completes.
- R8: After reset, in_ready is 1, both output valids are 0, and all tables are empty.
- R9: Configuration writes use cfg_sel 0 = route entry (cfg_ip prefix, cfg_len 0..32, cfg_port, cfg_nh), 1 = adjacency entry (cfg_ip address, cfg_mac), and 2 = own address (cfg_ip), each at slot cfg_idx. A write takes effect for descriptors accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header descriptor valid |
| in_ready | output | 1 | Engine can accept a descriptor |
| in_buf_id | input | 8 | Payload buffer tag |
| in_dst_ip | input | 32 | Destination IPv4 address |
| in_port | input | 4 | Ingress port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Table select (0 route, 1 adjacency, 2 own address) |
| cfg_idx | input | 4 | Table slot |
| cfg_ip | input | 32 | Prefix, adjacency address or own address |
| cfg_len | input | 6 | Route prefix length |
| cfg_port | input | 4 | Route egress port |
| cfg_nh | input | 32 | Route next-hop address |
| cfg_mac | input | 48 | Adjacency MAC |
| age_tick | input | 1 | Global adjacency age tick |
| age_limit | input | 8 | Ticks after which an adjacency entry expires |
| eg_valid | output | 1 | Forward descriptor valid |
| eg_ready | input | 1 | Forward descriptor accepted |
| eg_buf_id | output | 8 | Buffer tag |
| eg_port | output | 4 | Egress port |
| eg_mac | output | 48 | Next-hop MAC |
| punt_valid | output | 1 | Punt descriptor valid |
| punt_ready | input | 1 | Punt descriptor accepted |
| punt_buf_id | output | 8 | Buffer tag |
| punt_in_port | output | 4 | Ingress port of the punted packet |
| punt_reason | output | 2 | 0 local/control, 1 glean, 2 no route |
| punt_ip | output | 32 | Destination (reasons 0, 2) or next-hop (reason 1) |

## Verification
The hardest case to reach from the ports is the edge of adjacency expiry. A packet has to reach the adjacency stage exactly when an entry's age sits one tick below or at age_limit, and a rewrite that lands in the same cycle as a tick has to restore the entry. The stimulus reaches this with a small age_limit, tick pulses counted one by one, and a packet sent after each tick. Random traffic then mixes own-address, multicast-control, unrouted and overlapping-prefix destinations, with random output stalls, against a route set whose next hops are only partly resolved.

// File: rtl/l3fwd_pkg.sv
package l3fwd_pkg;
    typedef enum logic [1:0] {
        RSN_LOCAL   = 2'd0,
        RSN_GLEAN   = 2'd1,
        RSN_NOROUTE = 2'd2
    } punt_rsn_e;

    typedef enum logic [1:0] {
        CFG_ROUTE = 2'd0,
        CFG_ADJ   = 2'd1,
        CFG_LOCAL = 2'd2
    } cfg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_ADJ,
        ST_EMIT_FWD,
        ST_EMIT_PUNT
    } fwd_state_e;

    localparam logic [31:0] OSPF_ALL_ROUTERS = 32'hE000_0005;
endpackage

// File: rtl/fwd_route_lpm.sv
module fwd_route_lpm #(
    parameter int N  = 16,
    parameter int PW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [31:0]          wr_prefix,
    input  logic [5:0]           wr_len,
    input  logic [PW-1:0]        wr_port,
    input  logic [31:0]          wr_nh,
    input  logic [31:0]          key,
    output logic                 hit,
    output logic [PW-1:0]        port,
    output logic [31:0]          nh
);
    localparam int IW = $clog2(N);

    logic [N-1:0]  vld;
    logic [31:0]   pfx [N];
    logic [31:0]   msk [N];
    logic [5:0]    plen [N];
    logic [PW-1:0] pport [N];
    logic [31:0]   pnh [N];

    function automatic logic [31:0] len_mask(input logic [5:0] l);
        if (l == 6'd0)  return 32'd0;
        if (l >= 6'd32) return 32'hFFFF_FFFF;
        return 32'hFFFF_FFFF << (6'd32 - l);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && wr_idx == IW'(i)) begin
                    vld[i]   <= 1'b1;
                    msk[i]   <= len_mask(wr_len);
                    pfx[i]   <= wr_prefix & len_mask(wr_len);
                    plen[i]  <= (wr_len > 6'd32) ? 6'd32 : wr_len;
                    pport[i] <= wr_port;
                    pnh[i]   <= wr_nh;
                end
            end
        end
    end

    // Longest match wins; strict compare keeps the lower index on ties.
    always_comb begin
        logic [5:0] best;
        hit  = 1'b0;
        best = 6'd0;
        port = '0;
        nh   = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && ((key & msk[i]) == pfx[i]) && (!hit || plen[i] > best)) begin
                hit  = 1'b1;
                best = plen[i];
                port = pport[i];
                nh   = pnh[i];
            end
        end
    end
endmodule

// File: rtl/fwd_adj_cache.sv
module fwd_adj_cache #(
    parameter int N     = 16,
    parameter int AGE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [31:0]          wr_ip,
    input  logic [47:0]          wr_mac,
    input  logic                 tick,
    input  logic [AGE_W-1:0]     age_limit,
    input  logic [31:0]          key,
    output logic                 hit,
    output logic [47:0]          mac
);
    localparam int IW = $clog2(N);
    localparam logic [AGE_W:0] ONE = (AGE_W+1)'(1);

    logic [N-1:0]     vld;
    logic [31:0]      aip [N];
    logic [47:0]      amac [N];
    logic [AGE_W-1:0] age [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < N; i++) age[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && wr_idx == IW'(i)) begin
                    vld[i]  <= 1'b1;
                    age[i]  <= '0;
                    aip[i]  <= wr_ip;
                    amac[i] <= wr_mac;
                end else if (tick && vld[i]) begin
                    if (({1'b0, age[i]} + ONE) >= {1'b0, age_limit}) vld[i] <= 1'b0;
                    if (age[i] != '1) age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    // Scan downward so the lowest usable index supplies the MAC.
    always_comb begin
        hit = 1'b0;
        mac = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i] && (age[i] < age_limit) && aip[i] == key) begin
                hit = 1'b1;
                mac = amac[i];
            end
        end
    end
endmodule

// File: rtl/l3_fwd_engine.sv
module l3_fwd_engine
    import l3fwd_pkg::*;
#(
    parameter int BW    = 8,
    parameter int PW    = 4,
    parameter int RT_N  = 16,
    parameter int ADJ_N = 16,
    parameter int LOC_N = 2,
    parameter int AGE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [BW-1:0]          in_buf_id,
    input  logic [31:0]            in_dst_ip,
    input  logic [PW-1:0]          in_port,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [$clog2((RT_N > ADJ_N) ? RT_N : ADJ_N)-1:0] cfg_idx,
    input  logic [31:0]            cfg_ip,
    input  logic [5:0]             cfg_len,
    input  logic [PW-1:0]          cfg_port,
    input  logic [31:0]            cfg_nh,
    input  logic [47:0]            cfg_mac,
    input  logic                   age_tick,
    input  logic [AGE_W-1:0]       age_limit,
    output logic                   eg_valid,
    input  logic                   eg_ready,
    output logic [BW-1:0]          eg_buf_id,
    output logic [PW-1:0]          eg_port,
    output logic [47:0]            eg_mac,
    output logic                   punt_valid,
    input  logic                   punt_ready,
    output logic [BW-1:0]          punt_buf_id,
    output logic [PW-1:0]          punt_in_port,
    output logic [1:0]             punt_reason,
    output logic [31:0]            punt_ip
);
    localparam int CIW    = $clog2((RT_N > ADJ_N) ? RT_N : ADJ_N);
    localparam int RT_IW  = $clog2(RT_N);
    localparam int ADJ_IW = $clog2(ADJ_N);

    fwd_state_e state, state_nx;

    logic [BW-1:0]   hdr_buf;
    logic [31:0]     hdr_dst;
    logic [PW-1:0]   hdr_port;
    logic [PW-1:0]   port_q;
    logic [31:0]     nh_q;
    logic [47:0]     mac_q;
    logic [1:0]      rsn_q;
    logic [31:0]     pip_q;

    logic [31:0]     loc_ip [LOC_N];
    logic [LOC_N-1:0] loc_vld;
    logic [LOC_N-1:0] loc_match;
    logic            is_local;

    logic            rt_hit, adj_hit;
    logic [PW-1:0]   rt_port;
    logic [31:0]     rt_nh;
    logic [47:0]     adj_mac;

    fwd_route_lpm #(.N(RT_N), .PW(PW)) u_route (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_sel == CFG_ROUTE), .wr_idx(cfg_idx[RT_IW-1:0]),
        .wr_prefix(cfg_ip), .wr_len(cfg_len), .wr_port(cfg_port), .wr_nh(cfg_nh),
        .key(hdr_dst), .hit(rt_hit), .port(rt_port), .nh(rt_nh)
    );

    fwd_adj_cache #(.N(ADJ_N), .AGE_W(AGE_W)) u_adj (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_sel == CFG_ADJ), .wr_idx(cfg_idx[ADJ_IW-1:0]),
        .wr_ip(cfg_ip), .wr_mac(cfg_mac), .tick(age_tick), .age_limit(age_limit),
        .key(nh_q), .hit(adj_hit), .mac(adj_mac)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_vld <= '0;
        end else begin
            for (int i = 0; i < LOC_N; i++) begin
                if (cfg_we && cfg_sel == CFG_LOCAL && cfg_idx == CIW'(i)) begin
                    loc_vld[i] <= 1'b1;
                    loc_ip[i]  <= cfg_ip;
                end
            end
        end
    end

    for (genvar g = 0; g < LOC_N; g++) begin : g_loc
        assign loc_match[g] = loc_vld[g] && (loc_ip[g] == hdr_dst);
    end

    assign is_local = (|loc_match) || (hdr_dst == OSPF_ALL_ROUTERS);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (in_valid) state_nx = ST_ROUTE;
            ST_ROUTE:     state_nx = (is_local || !rt_hit) ? ST_EMIT_PUNT : ST_ADJ;
            ST_ADJ:       state_nx = adj_hit ? ST_EMIT_FWD : ST_EMIT_PUNT;
            ST_EMIT_FWD:  if (eg_ready) state_nx = ST_IDLE;
            ST_EMIT_PUNT: if (punt_ready) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_buf  <= '0;
            hdr_dst  <= '0;
            hdr_port <= '0;
            port_q   <= '0;
            nh_q     <= '0;
            mac_q    <= '0;
            rsn_q    <= '0;
            pip_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    hdr_buf  <= in_buf_id;
                    hdr_dst  <= in_dst_ip;
                    hdr_port <= in_port;
                end
                ST_ROUTE: begin
                    port_q <= rt_port;
                    nh_q   <= rt_nh;
                    pip_q  <= hdr_dst;
                    rsn_q  <= is_local ? RSN_LOCAL : RSN_NOROUTE;
                end
                ST_ADJ: begin
                    mac_q <= adj_mac;
                    rsn_q <= RSN_GLEAN;
                    pip_q <= nh_q;
                end
                default: ;
            endcase
        end
    end

    assign in_ready     = (state == ST_IDLE);
    assign eg_valid     = (state == ST_EMIT_FWD);
    assign punt_valid   = (state == ST_EMIT_PUNT);
    assign eg_buf_id    = hdr_buf;
    assign eg_port      = port_q;
    assign eg_mac       = mac_q;
    assign punt_buf_id  = hdr_buf;
    assign punt_in_port = hdr_port;
    assign punt_reason  = rsn_q;
    assign punt_ip      = pip_q;
endmodule

// File: rtl/l3_fwd_chk.sv
module l3_fwd_chk
    import l3fwd_pkg::*;
#(
    parameter int BW = 8,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [BW-1:0] in_buf_id,
    input logic [31:0]   in_dst_ip,
    input logic          eg_valid,
    input logic          eg_ready,
    input logic [BW-1:0] eg_buf_id,
    input logic [PW-1:0] eg_port,
    input logic [47:0]   eg_mac,
    input logic          punt_valid,
    input logic          punt_ready,
    input logic [BW-1:0] punt_buf_id,
    input logic [1:0]    punt_reason,
    input logic [31:0]   punt_ip
);
    logic [BW-1:0] acc_buf;
    logic [31:0]   acc_dst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_buf <= '0;
            acc_dst <= '0;
        end else if (in_valid && in_ready) begin
            acc_buf <= in_buf_id;
            acc_dst <= in_dst_ip;
        end
    end

    // R7: never both outputs at once
    a_r7_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(eg_valid && punt_valid));

    // R7: no acceptance while a result is pending
    a_r7_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (eg_valid || punt_valid) |-> !in_ready);

    a_r7_hold_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (eg_valid && !eg_ready) |=> (eg_valid && $stable(eg_buf_id) && $stable(eg_port) && $stable(eg_mac)));

    a_r7_hold_punt: assert property (@(posedge clk) disable iff (!rst_n)
        (punt_valid && !punt_ready) |=> (punt_valid && $stable(punt_buf_id) && $stable(punt_reason) && $stable(punt_ip)));

    // R5: tag follows the accepted descriptor
    a_r5_tag_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        eg_valid |-> (eg_buf_id == acc_buf));

    a_r5_tag_punt: assert property (@(posedge clk) disable iff (!rst_n)
        punt_valid |-> (punt_buf_id == acc_buf));

    // R1: the routing multicast alias is always punted as local
    a_r1_alias_punted: assert property (@(posedge clk) disable iff (!rst_n)
        (punt_valid && acc_dst == OSPF_ALL_ROUTERS) |-> (punt_reason == 2'd0));

    a_r1_alias_never_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        eg_valid |-> (acc_dst != OSPF_ALL_ROUTERS));

    // R3: reason code stays within the defined set
    a_r3_reason_legal: assert property (@(posedge clk) disable iff (!rst_n)
        punt_valid |-> (punt_reason != 2'd3));
endmodule

bind l3_fwd_engine l3_fwd_chk #(.BW(BW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_buf_id(in_buf_id), .in_dst_ip(in_dst_ip),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_buf_id(eg_buf_id),
    .eg_port(eg_port), .eg_mac(eg_mac),
    .punt_valid(punt_valid), .punt_ready(punt_ready), .punt_buf_id(punt_buf_id),
    .punt_reason(punt_reason), .punt_ip(punt_ip)
);

// File: tb/sim_l3_fwd_engine.sv
module sim_l3_fwd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_buf_id = '0;
    logic [31:0] in_dst_ip = '0;
    logic [3:0]  in_port = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_ip = '0, cfg_nh = '0;
    logic [5:0]  cfg_len = '0;
    logic [3:0]  cfg_port = '0;
    logic [47:0] cfg_mac = '0;
    logic        age_tick = 1'b0;
    logic [7:0]  age_limit = 8'd255;
    logic        eg_valid, eg_ready = 1'b0;
    logic [7:0]  eg_buf_id;
    logic [3:0]  eg_port;
    logic [47:0] eg_mac;
    logic        punt_valid, punt_ready = 1'b0;
    logic [7:0]  punt_buf_id;
    logic [3:0]  punt_in_port;
    logic [1:0]  punt_reason;
    logic [31:0] punt_ip;

    always #2 clk = ~clk;

    l3_fwd_engine u0 (.*);

    int total = 0, bad = 0;
    bit done = 1'b0;

    // Reference tables
    bit          m_rv [16];
    logic [31:0] m_rp [16];
    logic [5:0]  m_rl [16];
    logic [3:0]  m_rport [16];
    logic [31:0] m_rnh [16];
    bit          m_av [16];
    logic [31:0] m_aip [16];
    logic [47:0] m_amac [16];
    int          m_age [16];
    bit          m_lv [2];
    logic [31:0] m_lip [2];

    bit          x_fwd;
    logic [3:0]  x_port;
    logic [47:0] x_mac;
    logic [1:0]  x_rsn;
    logic [31:0] x_pip;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_mask(input logic [5:0] l);
        if (l == 0) return 32'd0;
        return 32'hFFFF_FFFF << (32 - l);
    endfunction

    function automatic void predict(input logic [31:0] d);
        int best; bit hit; logic [31:0] nh;
        x_fwd = 0; x_port = 0; x_mac = 0;
        if (d == 32'hE000_0005 || (m_lv[0] && m_lip[0] == d) || (m_lv[1] && m_lip[1] == d)) begin
            x_rsn = 2'd0; x_pip = d; return;
        end
        hit = 0; best = -1; nh = 0;
        for (int i = 0; i < 16; i++)
            if (m_rv[i] && ((d & mk_mask(m_rl[i])) == (m_rp[i] & mk_mask(m_rl[i]))) && int'(m_rl[i]) > best) begin
                hit = 1; best = int'(m_rl[i]); x_port = m_rport[i]; nh = m_rnh[i];
            end
        if (!hit) begin x_rsn = 2'd2; x_pip = d; return; end
        for (int i = 0; i < 16; i++)
            if (m_av[i] && m_age[i] < int'(age_limit) && m_aip[i] == nh) begin
                x_fwd = 1; x_mac = m_amac[i]; return;
            end
        x_rsn = 2'd1; x_pip = nh;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input int idx, input logic [31:0] ip,
                             input logic [5:0] len, input logic [3:0] prt, input logic [31:0] nh,
                             input logic [47:0] mac, input bit with_tick);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_ip = ip; cfg_len = len;
        cfg_port = prt; cfg_nh = nh; cfg_mac = mac; age_tick = with_tick;
        if (with_tick)
            for (int i = 0; i < 16; i++)
                if (!(sel == 2'd1 && i == idx) && m_av[i]) begin
                    if (m_age[i] + 1 >= int'(age_limit)) m_av[i] = 0;
                    if (m_age[i] < 255) m_age[i]++;
                end
        case (sel)
            2'd0: begin m_rv[idx] = 1; m_rp[idx] = ip; m_rl[idx] = len; m_rport[idx] = prt; m_rnh[idx] = nh; end
            2'd1: begin m_av[idx] = 1; m_aip[idx] = ip; m_amac[idx] = mac; m_age[idx] = 0; end
            default: begin m_lv[idx] = 1; m_lip[idx] = ip; end
        endcase
        @(negedge clk);
        cfg_we = 0; age_tick = 0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        age_tick = 1;
        for (int i = 0; i < 16; i++)
            if (m_av[i]) begin
                if (m_age[i] + 1 >= int'(age_limit)) m_av[i] = 0;
                if (m_age[i] < 255) m_age[i]++;
            end
        @(negedge clk);
        age_tick = 0;
    endtask

    task automatic send(input logic [7:0] b, input logic [31:0] d, input logic [3:0] ip,
                        input int stall, input string tag);
        int w;
        logic [63:0] snap;
        predict(d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_buf_id = b; in_dst_ip = d; in_port = ip;
        @(negedge clk);
        in_valid = 0;
        w = 0;
        while (!eg_valid && !punt_valid && w < 50) begin @(negedge clk); w++; end
        chk(x_fwd ? eg_valid : punt_valid, {tag, " R7 output kind"}, {eg_valid, punt_valid}, {x_fwd, !x_fwd});
        snap = eg_valid ? {eg_port, eg_mac} : {punt_reason, punt_ip};
        if (stall > 0) begin
            bit held = 1;
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                if (!(eg_valid || punt_valid)) held = 0;
                if ((eg_valid ? {eg_port, eg_mac} : {punt_reason, punt_ip}) != snap) held = 0;
            end
            chk(held, {tag, " R7 held under stall"}, 64'(held), 64'd1);
        end
        if (x_fwd) begin
            chk(eg_port == x_port, {tag, " R2 port"}, 64'(eg_port), 64'(x_port));
            chk(eg_mac == x_mac, {tag, " R2 mac"}, 64'(eg_mac), 64'(x_mac));
            chk(eg_buf_id == b, {tag, " R5 tag"}, 64'(eg_buf_id), 64'(b));
        end else begin
            chk(punt_reason == x_rsn, {tag, " R1/R3/R4 reason"}, 64'(punt_reason), 64'(x_rsn));
            chk(punt_ip == x_pip, {tag, " R1/R3/R4 punt_ip"}, 64'(punt_ip), 64'(x_pip));
            chk(punt_buf_id == b && punt_in_port == ip, {tag, " R5 tag/port"},
                {punt_buf_id, punt_in_port}, {b, ip});
        end
        eg_ready = 1; punt_ready = 1;
        @(negedge clk);
        eg_ready = 0; punt_ready = 0;
        chk(in_ready && !eg_valid && !punt_valid, {tag, " R7 single result"},
            {in_ready, eg_valid, punt_valid}, 64'b100);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin m_rv[i] = 0; m_av[i] = 0; m_age[i] = 0; end
        m_lv[0] = 0; m_lv[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8
        chk(in_ready && !eg_valid && !punt_valid, "R8 reset outputs",
            {in_ready, eg_valid, punt_valid}, 64'b100);

        send(8'h01, 32'hE000_0005, 4'd1, 0, "R1 alias, empty tables");
        send(8'h02, 32'h0A01_0203, 4'd2, 0, "R3 no route, R8 empty");
        // R9 route write, R4 glean
        cfg_write(2'd0, 0, 32'h0A00_0000, 6'd8, 4'd3, 32'hC0A8_0001, 48'h0, 0);
        send(8'h03, 32'h0A01_0203, 4'd2, 0, "R4 glean");
        cfg_write(2'd1, 2, 32'hC0A8_0001, 0, 0, 0, 48'h0011_2233_4455, 0);
        send(8'h04, 32'h0A01_0203, 4'd2, 2, "R2 /8 forward");
        cfg_write(2'd0, 7, 32'h0A01_0000, 6'd16, 4'd5, 32'hC0A8_0002, 48'h0, 0);
        cfg_write(2'd1, 9, 32'hC0A8_0002, 0, 0, 0, 48'h00AA_BBCC_DDEE, 0);
        send(8'h05, 32'h0A01_0203, 4'd2, 0, "R2 longer prefix");
        send(8'h06, 32'h0A02_0203, 4'd2, 0, "R2 shorter only");
        cfg_write(2'd2, 1, 32'h0A01_0203, 0, 0, 0, 0, 0);
        send(8'h07, 32'h0A01_0203, 4'd6, 3, "R1 own address beats route");
        // R6 duplicate address: lower index wins
        cfg_write(2'd1, 1, 32'hC0A8_0002, 0, 0, 0, 48'h0000_0000_0101, 0);
        send(8'h08, 32'h0A01_0909, 4'd0, 0, "R6 lowest duplicate");
        // R6 aging at limit 3
        age_limit = 8'd3;
        cfg_write(2'd1, 1, 32'hC0A8_0002, 0, 0, 0, 48'h0000_0000_0202, 0);
        cfg_write(2'd1, 9, 32'hC0A8_0099, 0, 0, 0, 48'h0, 0);
        tick_once(); tick_once();
        send(8'h09, 32'h0A01_0909, 4'd0, 0, "R6 age below limit");
        tick_once();
        send(8'h0A, 32'h0A01_0909, 4'd0, 0, "R6 expired glean");
        cfg_write(2'd1, 1, 32'hC0A8_0002, 0, 0, 0, 48'h0000_0000_0303, 1);
        tick_once(); tick_once();
        send(8'h0B, 32'h0A01_0909, 4'd0, 0, "R6 write beats tick");

        // Random phase
        age_limit = 8'd255;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] p = {8'd10, 24'($urandom)};
            cfg_write(2'd0, i, p, 6'(8 + $urandom % 17), 4'($urandom),
                      {24'hC0A800, 8'($urandom % 20)}, 0, 0);
        end
        for (int i = 0; i < 16; i++)
            cfg_write(2'd1, i, {24'hC0A800, 8'(i)}, 0, 0, 0, {16'h0, $urandom}, 0);
        for (int n = 0; n < 300; n++) begin
            int r = $urandom % 10;
            logic [31:0] d;
            if (r == 0)      d = 32'hE000_0005;
            else if (r == 1) d = 32'h0A01_0203;
            else if (r == 2) d = {m_rp[$urandom % 16][31:16], 16'($urandom)};
            else             d = {8'(10 + $urandom % 2), 24'($urandom)};
            send(8'($urandom), d, 4'($urandom), ($urandom % 4 == 0) ? 2 : 0, "random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R7 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule